// File: doc/BRIEF.md
# Clocked Serial Frame Receiver with Break Recovery

This block is the receive half of a half-duplex, host-clocked serial link. An external host supplies the clock and changes the data line on the falling edge. The receiver samples the line on every rising edge. While idle the line is high. A low sample marks a start bit. The receiver then collects eight data bits, least significant bit first, an even-parity bit and two stop bits. When a frame passes every check, the byte goes to the access layer above together with a single-cycle valid strobe.

A bad parity bit or a low stop bit raises a sticky error flag, and the receiver becomes locked. In the locked state it ignores traffic until the host sends a break, which is a line held low for at least a full frame time of twelve samples. A break gives one strobe however long it lasts, clears both error flags and unlocks the receiver. The receiver looks for a new start bit only after the line has gone high again. The upper layer can also clear the error flags with an acknowledge input. The acknowledge does not unlock the receiver.

Top module: `syncframe_rx`

## Requirements
- R1: After reset, rx_valid, break_pulse, frame_err, parity_err and rx_locked are all 0 and rx_data is 0.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, one parity bit and two high stop bits. When the second stop bit is sampled high, the parity is correct and no break occurred, rx_data takes the byte and rx_valid is 1 for exactly one cycle, starting at the edge that sampled the second stop bit.
- R3: The parity bit must equal the XOR of the eight data bits. On a mismatch, parity_err is set at the final edge of the frame, rx_valid stays 0 and rx_locked becomes 1.
- R4: If either stop bit is sampled low and the frame is not a break, frame_err is set at the final edge of the frame, rx_valid stays 0 and rx_locked becomes 1.
- R5: While rx_locked is 1, complete well-formed frames produce no rx_valid.
- R6: Twelve consecutive low samples form a break. This applies in idle, in the middle of a frame and while locked. A break gives a one-cycle break_pulse at the edge of the twelfth low sample, clears frame_err and parity_err, and clears rx_locked. An all-zero frame counts as a break, not as a frame error.
- R7: A break held low longer than twelve samples gives only one break_pulse. No start bit is taken until the line has been sampled high.
- R8: A sampled err_ack clears frame_err and parity_err at the next edge. It leaves rx_locked unchanged.
- R9: rx_valid and break_pulse are never 1 together, and neither is 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied clock; line sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial data line, idle high |
| err_ack | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |
| frame_err | output | 1 | Sticky flag: a stop bit was sampled low |
| parity_err | output | 1 | Sticky flag: parity mismatch |
| break_pulse | output | 1 | One-cycle strobe when a break is recognised |
| rx_locked | output | 1 | Receiver waits for a break after an error |

## Verification
The assertions check the following on every cycle:
- strobes are exclusive and last one cycle;
- no valid strobe appears while locked;
- a break strobe always comes with cleared flags and an unlocked receiver;
- an acknowledge clears the flags but keeps the lock;
- a rising error flag always comes with the lock;
- a valid strobe always follows a high stop sample.

Only the bench scenarios can show the following:
- the byte value and bit order over all 256 codes;
- the parity calculation;
- the exact twelve-sample break threshold;
- a long break counted once;
- a stuck-low tail that is not mistaken for a start bit.

// File: rtl/syncrx_pkg.sv
package syncrx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_LOCK = 2'd2,
    RX_HOLD = 2'd3
  } rx_state_e;
endpackage

// File: rtl/syncrx_rst_sync.sv
module syncrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/syncrx_lowrun.sv
module syncrx_lowrun #(
  parameter int RUN_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic run_hit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  // saturating count of consecutive low samples
  always_comb begin
    if (line)                  cnt_d = '0;
    else if (cnt_q != RUN_FULL) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  // the sample taken at this edge completes the run
  assign run_hit = !line && (cnt_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/syncrx_shift.sv
module syncrx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              line,
  output logic [DATA_W-1:0] word,
  output logic              par
);
  logic [DATA_W-1:0] word_q, word_d;
  logic              par_q, par_d;
  logic              upd;

  assign upd = clr || shift_en;

  always_comb begin
    word_d = word_q;
    par_d  = par_q;
    if (clr) begin
      word_d = '0;
      par_d  = 1'b0;
    end else if (shift_en) begin
      word_d = {line, word_q[DATA_W-1:1]};  // first bit ends in bit 0
      par_d  = par_q ^ line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      par_q  <= 1'b0;
    end else if (upd) begin
      word_q <= word_d;
      par_q  <= par_d;
    end
  end

  assign word = word_q;
  assign par  = par_q;
endmodule

// File: rtl/syncrx_ctrl.sv
module syncrx_ctrl
  import syncrx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic run_hit,
  input  logic par_acc,
  output logic clr,
  output logic shift_en,
  output logic ev_valid,
  output logic ev_ferr,
  output logic ev_perr,
  output logic ev_brk,
  output logic locked
);
  localparam int FRAME_LEN = 2 + DATA_W + STOP_BITS;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0] POS_DLAST = POS_W'(DATA_W);
  localparam logic [POS_W-1:0] POS_PAR   = POS_W'(DATA_W + 1);
  localparam logic [POS_W-1:0] POS_END   = POS_W'(FRAME_LEN - 1);

  rx_state_e        state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             par_bad_q, par_bad_d;
  logic             stop_bad_q, stop_bad_d;
  logic             stop_fail;

  assign stop_fail = stop_bad_q || !line;

  always_comb begin
    state_d    = state_q;
    pos_d      = pos_q;
    par_bad_d  = par_bad_q;
    stop_bad_d = stop_bad_q;
    clr        = 1'b0;
    shift_en   = 1'b0;
    ev_valid   = 1'b0;
    ev_ferr    = 1'b0;
    ev_perr    = 1'b0;
    ev_brk     = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (!line) begin
          state_d    = RX_BITS;
          pos_d      = POS_FIRST;
          clr        = 1'b1;
          par_bad_d  = 1'b0;
          stop_bad_d = 1'b0;
        end
      end
      RX_BITS: begin
        if (pos_q <= POS_DLAST)      shift_en   = 1'b1;
        else if (pos_q == POS_PAR)   par_bad_d  = line ^ par_acc;
        else                         stop_bad_d = stop_fail;
        if (pos_q == POS_END) begin
          if (run_hit) begin
            ev_brk  = 1'b1;
            state_d = RX_HOLD;
          end else if (stop_fail || par_bad_q) begin
            ev_ferr = stop_fail;
            ev_perr = par_bad_q;
            state_d = RX_LOCK;
          end else begin
            ev_valid = 1'b1;
            state_d  = RX_IDLE;
          end
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      RX_LOCK: begin
        if (run_hit) begin
          ev_brk  = 1'b1;
          state_d = RX_HOLD;
        end
      end
      RX_HOLD: begin
        if (line) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      pos_q      <= '0;
      par_bad_q  <= 1'b0;
      stop_bad_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pos_q      <= pos_d;
      par_bad_q  <= par_bad_d;
      stop_bad_q <= stop_bad_d;
    end
  end

  assign locked = (state_q == RX_LOCK);
endmodule

// File: rtl/syncframe_rx.sv
module syncframe_rx #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              err_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              parity_err,
  output logic              break_pulse,
  output logic              rx_locked
);
  localparam int FRAME_LEN = 2 + DATA_W + STOP_BITS;

  logic              srst_n;
  logic              run_hit, par_acc, clr, shift_en;
  logic              ev_valid, ev_ferr, ev_perr, ev_brk;
  logic [DATA_W-1:0] word;

  logic [DATA_W-1:0] data_q;
  logic              valid_q, brk_q, ferr_q, ferr_d, perr_q, perr_d;

  syncrx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(srst_n)
  );

  syncrx_lowrun #(.RUN_LEN(FRAME_LEN)) u_run (
    .clk(clk), .rst_n(srst_n), .line(rx_line), .run_hit(run_hit)
  );

  syncrx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .clr(clr), .shift_en(shift_en),
    .line(rx_line), .word(word), .par(par_acc)
  );

  syncrx_ctrl #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .line(rx_line), .run_hit(run_hit),
    .par_acc(par_acc), .clr(clr), .shift_en(shift_en),
    .ev_valid(ev_valid), .ev_ferr(ev_ferr), .ev_perr(ev_perr),
    .ev_brk(ev_brk), .locked(rx_locked)
  );

  // sticky flags: break clears, new error sets, acknowledge clears
  always_comb begin
    if (ev_brk)       ferr_d = 1'b0;
    else if (ev_ferr) ferr_d = 1'b1;
    else if (err_ack) ferr_d = 1'b0;
    else              ferr_d = ferr_q;
    if (ev_brk)       perr_d = 1'b0;
    else if (ev_perr) perr_d = 1'b1;
    else if (err_ack) perr_d = 1'b0;
    else              perr_d = perr_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      brk_q   <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= ev_valid;
      brk_q   <= ev_brk;
      ferr_q  <= ferr_d;
      perr_q  <= perr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       data_q <= '0;
    else if (ev_valid) data_q <= word;
  end

  assign rx_data     = data_q;
  assign rx_valid    = valid_q;
  assign break_pulse = brk_q;
  assign frame_err   = ferr_q;
  assign parity_err  = perr_q;
endmodule

// File: rtl/syncrx_chk.sv
module syncrx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_line,
  input logic err_ack,
  input logic rx_valid,
  input logic break_pulse,
  input logic frame_err,
  input logic parity_err,
  input logic rx_locked
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && break_pulse));
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_break_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    break_pulse |=> !break_pulse);
  assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_locked |-> !rx_valid);
  assert_break_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    break_pulse |-> (!rx_locked && !frame_err && !parity_err));
  assert_ack_keeps_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ack && rx_locked && rx_line) |=> (rx_locked && !frame_err && !parity_err));
  assert_perr_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> (rx_locked && !rx_valid));
  assert_ferr_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> (rx_locked && !rx_valid));
  assert_valid_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_line));
endmodule

bind syncframe_rx syncrx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .err_ack(err_ack),
  .rx_valid(rx_valid), .break_pulse(break_pulse), .frame_err(frame_err),
  .parity_err(parity_err), .rx_locked(rx_locked)
);

// File: tb/sim_syncframe_rx.sv
`timescale 1ns/1ps
module sim_syncframe_rx;
  logic       clk = 1'b0;
  logic       rst_n, rx_line, err_ack;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, parity_err, break_pulse, rx_locked;

  int n_chk = 0;
  int n_bad = 0;
  int vcnt  = 0;
  int bcnt  = 0;

  always #2.5 clk = ~clk;

  syncframe_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .err_ack(err_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err), .break_pulse(break_pulse), .rx_locked(rx_locked)
  );

  // pulse counters sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (rx_valid)    vcnt++;
    if (break_pulse) bcnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    @(negedge clk);
    rx_line = b;
  endtask

  // drives a full frame and returns at the negedge after the last sample
  task automatic send(input logic [7:0] d, input logic flip, input logic s1, input logic s2);
    drive(1'b0);
    for (int i = 0; i < 8; i++) drive(d[i]);
    drive((^d) ^ flip);
    drive(s1);
    drive(s2);
    @(negedge clk);
    rx_line = 1'b1;
  endtask

  // drives n low samples, returns after the last one with the line still low
  task automatic send_low(input int n);
    for (int i = 0; i < n; i++) drive(1'b0);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v0, b0;
    logic [7:0] pbytes [4];
    pbytes[0] = 8'h01; pbytes[1] = 8'h80; pbytes[2] = 8'hA5; pbytes[3] = 8'hFE;

    rst_n = 1'b0; rx_line = 1'b1; err_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 break_pulse", break_pulse, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 parity_err", parity_err, 0);
    chk("R1 rx_locked", rx_locked, 0);
    chk("R1 rx_data", rx_data, 0);

    // R2: every byte value, correct framing
    for (int d = 0; d < 256; d++) begin
      v0 = vcnt;
      send(8'(d), 1'b0, 1'b1, 1'b1);
      chk("R2 rx_valid", rx_valid, 1);
      chk("R2 rx_data", rx_data, d);
      chk("R2 valid count", vcnt, v0 + 1);
      idle(1);
      chk("R9 valid one cycle", rx_valid, 0);
      chk("R2 no error", frame_err | parity_err | rx_locked, 0);
    end

    // R3, R5, R8, R6 around a parity error
    foreach (pbytes[k]) begin
      v0 = vcnt;
      send(pbytes[k], 1'b1, 1'b1, 1'b1);
      chk("R3 parity_err", parity_err, 1);
      chk("R3 frame_err", frame_err, 0);
      chk("R3 rx_locked", rx_locked, 1);
      chk("R3 no valid", vcnt, v0);
      idle(2);
      send(pbytes[k], 1'b0, 1'b1, 1'b1);
      idle(1);
      chk("R5 locked drops frame", vcnt, v0);
      chk("R5 still locked", rx_locked, 1);
      @(negedge clk) err_ack = 1'b1;
      @(negedge clk) err_ack = 1'b0;
      chk("R8 ack clears parity_err", parity_err, 0);
      chk("R8 ack keeps lock", rx_locked, 1);
      b0 = bcnt;
      send_low(12);
      rx_line = 1'b1;
      chk("R6 break_pulse", break_pulse, 1);
      chk("R6 unlocked", rx_locked, 0);
      chk("R6 break count", bcnt, b0 + 1);
      idle(2);
    end

    // R4: first stop bit low, then R6 break clears without acknowledge
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R4 frame_err stop1", frame_err, 1);
    chk("R4 parity_err", parity_err, 0);
    chk("R4 rx_locked", rx_locked, 1);
    chk("R4 no valid", rx_valid, 0);
    idle(2);
    send_low(11);
    rx_line = 1'b1;
    chk("R6 eleven lows no break", break_pulse, 0);
    chk("R6 still locked", rx_locked, 1);
    idle(1);
    send_low(12);
    rx_line = 1'b1;
    chk("R6 break clears frame_err", frame_err, 0);
    chk("R6 unlocked after frame error", rx_locked, 0);
    idle(2);

    // R4: second stop bit low
    send(8'hC3, 1'b0, 1'b1, 1'b0);
    chk("R4 frame_err stop2", frame_err, 1);
    chk("R4 locked stop2", rx_locked, 1);
    idle(2);
    @(negedge clk) err_ack = 1'b1;
    @(negedge clk) err_ack = 1'b0;
    chk("R8 ack clears frame_err", frame_err, 0);
    chk("R8 lock kept", rx_locked, 1);
    send_low(12);
    rx_line = 1'b1;
    idle(2);

    // R6: all-zero frame from idle is a break, not a frame error
    b0 = bcnt;
    send(8'h00, 1'b0, 1'b0, 1'b0);
    chk("R6 zero frame is break", break_pulse, 1);
    chk("R6 zero frame no frame_err", frame_err, 0);
    chk("R6 zero frame not locked", rx_locked, 0);
    chk("R9 no valid with break", rx_valid, 0);
    idle(2);

    // R7: extended break, one event, no start while low
    b0 = bcnt;
    v0 = vcnt;
    send_low(12);
    repeat (20) @(negedge clk);
    rx_line = 1'b1;
    idle(2);
    chk("R7 single break event", bcnt, b0 + 1);
    chk("R7 no lock during long low", rx_locked, 0);
    chk("R7 no frame_err during long low", frame_err, 0);
    chk("R7 no valid during long low", vcnt, v0);
    send(8'h5A, 1'b0, 1'b1, 1'b1);
    chk("R7 start after high", rx_valid, 1);
    chk("R7 data after break", rx_data, 8'h5A);
    idle(2);

    // R1: reset while locked
    send(8'h77, 1'b1, 1'b1, 1'b1);
    chk("R1 pre-reset lock", rx_locked, 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    chk("R1 reset clears lock", rx_locked, 0);
    chk("R1 reset clears parity_err", parity_err, 0);
    chk("R1 reset clears data", rx_data, 0);

    finish_run();
  end
endmodule